// File: doc/BRIEF.md
# IO Page Table Walker with Level Skipping

The walker turns a 48-bit IO virtual address from a DMA request into a 52-bit physical address. It reads 64-bit entries of a multi-level radix table in memory, one at a time, starting from a root table pointer and a starting level. An entry can point straight to a table several levels lower, which jumps over intermediate tables. An entry can also end the walk above level 1 to map a large page. The result is either a physical address or a fault with a 2-bit type code.

All three data paths use valid/ready. The request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while no walk is in progress, so at most one walk is outstanding. Entry reads are offered on `mem_req_*`. The address holds steady while `mem_req_ready` is low. The memory side returns exactly one `mem_rsp_valid` beat per accepted read, and only while `mem_rsp_ready` is high. The result on `rsp_*` stays on the port, unchanged, until `rsp_ready` takes it.

Top module: `iopt_walker`

## Requirements
- R1: After reset `req_ready` is 1, and `mem_req_valid` and `rsp_valid` are 0.
- R2: `req_ready` is 0 from the cycle after a request is taken until the cycle after its result is accepted, so only one walk is in flight.
- R3: An entry read at level L goes to address root*4096 + idx*8. Here idx is virtual address bits [12+9L-1 : 12+9(L-1)] (47:39 for level 4, 20:12 for level 1), and it is 0 at levels 5 and 6. The address is 8-byte aligned and holds steady while `mem_req_ready` is low.
- R4: The entry layout is: bit 0 present, bits 51:12 next table or page address, bits 11:9 next-level code. An entry with bit 0 clear ends the walk with fault type 1 (not present).
- R5: Fault type 2 (invalid entry) is raised in three cases: a next-level code of 7, a next-level code not below the current level, or a starting level of 0 or above 6. A bad starting level is reported without any memory read.
- R6: A next-level code N below the current level L minus 1 jumps to level N. The virtual address bits of the skipped levels, [12+9(L-1)-1 : 12+9N], must all be 0, or the walk ends with fault type 3. A starting level below 4 leaves the bits above 12+9L-1 unused. Those bits must also be 0, or fault type 3 is reported with no memory read.
- R7: A next-level code of 0 is a leaf. At level L the physical address takes the low 12+9(L-1) bits from the virtual address and the remaining bits from entry bits 51 and below. A level-2 leaf is therefore a 2 MB page with bits 20:0 passed through.
- R8: A successful walk reports `rsp_fault`=0 and `rsp_ftype`=0. A failed walk reports `rsp_fault`=1 and `rsp_pa`=0. All result fields hold steady while `rsp_ready` is low.
- R9: A memory response is accepted only while `mem_rsp_ready` is high, which is from the cycle after a read is accepted until its data arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_iova | input | 48 | IO virtual address |
| req_root | input | 40 | Root table page number (address bits 51:12) |
| req_level | input | 3 | Level of the root table |
| mem_req_valid | output | 1 | Entry read offered |
| mem_req_ready | input | 1 | Memory takes the read |
| mem_req_addr | output | 52 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_ready | output | 1 | Walker waiting for entry data |
| mem_rsp_data | input | 64 | Entry contents |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Result accepted |
| rsp_pa | output | 52 | Physical address (0 on fault) |
| rsp_fault | output | 1 | Walk failed |
| rsp_ftype | output | 2 | 0 none, 1 not present, 2 invalid entry, 3 skipped index nonzero |

## Verification
The hardest case to reach is a skip whose skipped index bits are only partly nonzero, combined with stalls on both memory channels. The bench builds tables in which a level-4 entry jumps to level 2 and a level-3 entry jumps to level 1. It then sweeps virtual addresses that land on those entries, with zero and nonzero values in the skipped fields. Random ready and latency values are applied throughout, so a fault can arrive while a read is stalled. Starting levels 3, 5 and 6 are also driven, which exercises unused-top-bit checks and index positions past bit 47.

// File: rtl/iopt_pkg.sv
package iopt_pkg;
  localparam int VA_W    = 48;
  localparam int PA_W    = 52;
  localparam int PG_W    = 12;
  localparam int IDX_W   = 9;
  localparam int LVL_W   = 3;
  localparam int MAX_LVL = 6;
  localparam int ENT_W   = 64;

  typedef enum logic [1:0] {
    FT_NONE    = 2'd0,
    FT_NOTPRES = 2'd1,
    FT_BADENT  = 2'd2,
    FT_SKIPNZ  = 2'd3
  } fault_e;

  typedef enum logic [1:0] {
    ST_IDLE, ST_FETCH, ST_WAIT, ST_RESP
  } wstate_e;
endpackage

// File: rtl/iopt_span.sv
// Mask of the address bits below the top of a given level's index field.
module iopt_span #(
  parameter int W     = 52,
  parameter int PG_W  = 12,
  parameter int IDX_W = 9,
  parameter int LVL_W = 3
) (
  input  logic [LVL_W-1:0] lvl,
  output logic [W-1:0]     below
);
  int n;
  always_comb begin
    n = PG_W + IDX_W * int'(lvl);
    for (int i = 0; i < W; i++) below[i] = (i < n);
  end
endmodule

// File: rtl/iopt_entaddr.sv
// Entry byte address: table base plus the level's index scaled by entry size.
module iopt_entaddr #(
  parameter int VA_W  = 48,
  parameter int PA_W  = 52,
  parameter int PG_W  = 12,
  parameter int IDX_W = 9,
  parameter int LVL_W = 3,
  parameter int ENT_SH = 3
) (
  input  logic [PA_W-PG_W-1:0] base,
  input  logic [VA_W-1:0]      va,
  input  logic [LVL_W-1:0]     lvl,
  output logic [PA_W-1:0]      addr
);
  localparam int EXT_W = PG_W + IDX_W * (2 ** LVL_W);

  logic [EXT_W-1:0] vext;
  logic [IDX_W-1:0] idx;
  int               sh;

  always_comb begin
    vext = EXT_W'(va);
    sh   = (lvl == '0) ? 0 : PG_W + IDX_W * (int'(lvl) - 1);
    idx  = IDX_W'(vext >> sh);
    addr = {base, {PG_W{1'b0}}} | (PA_W'(idx) << ENT_SH);
  end
endmodule

// File: rtl/iopt_walker.sv
module iopt_walker
  import iopt_pkg::*;
#(
  parameter int P_VA_W    = VA_W,
  parameter int P_PA_W    = PA_W,
  parameter int P_PG_W    = PG_W,
  parameter int P_IDX_W   = IDX_W,
  parameter int P_LVL_W   = LVL_W,
  parameter int P_MAX_LVL = MAX_LVL,
  parameter int P_ENT_W   = ENT_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [P_VA_W-1:0]         req_iova,
  input  logic [P_PA_W-P_PG_W-1:0]  req_root,
  input  logic [P_LVL_W-1:0]        req_level,
  output logic                      mem_req_valid,
  input  logic                      mem_req_ready,
  output logic [P_PA_W-1:0]         mem_req_addr,
  input  logic                      mem_rsp_valid,
  output logic                      mem_rsp_ready,
  input  logic [P_ENT_W-1:0]        mem_rsp_data,
  output logic                      rsp_valid,
  input  logic                      rsp_ready,
  output logic [P_PA_W-1:0]         rsp_pa,
  output logic                      rsp_fault,
  output logic [1:0]                rsp_ftype
);
  localparam int BASE_W = P_PA_W - P_PG_W;
  localparam int NL_LSB = P_PG_W - P_LVL_W;
  localparam logic [P_LVL_W-1:0] NL_RSVD = '1;

  wstate_e              st_q;
  logic [P_VA_W-1:0]    va_q;
  logic [BASE_W-1:0]    base_q;
  logic [P_LVL_W-1:0]   lvl_q;
  logic [P_PA_W-1:0]    pa_q;
  fault_e               ft_q;

  logic [P_LVL_W-1:0]   nl, lvl_m1;
  logic                 present, skip_bad, start_lvl_bad, start_skip;
  logic [P_PA_W-1:0]    off_mask, leaf_pa;
  logic [P_VA_W-1:0]    nl_mask, st_mask;
  logic                 unused_rsvd;

  assign nl          = mem_rsp_data[NL_LSB +: P_LVL_W];
  assign present     = mem_rsp_data[0];
  assign lvl_m1      = lvl_q - 1'b1;
  assign unused_rsvd = ^{mem_rsp_data[P_ENT_W-1:P_PA_W], mem_rsp_data[NL_LSB-1:1]};

  iopt_entaddr #(.VA_W(P_VA_W), .PA_W(P_PA_W), .PG_W(P_PG_W), .IDX_W(P_IDX_W),
                 .LVL_W(P_LVL_W), .ENT_SH(3))
    u_addr (.base(base_q), .va(va_q), .lvl(lvl_q), .addr(mem_req_addr));

  iopt_span #(.W(P_PA_W), .PG_W(P_PG_W), .IDX_W(P_IDX_W), .LVL_W(P_LVL_W))
    u_off (.lvl(lvl_m1), .below(off_mask));
  iopt_span #(.W(P_VA_W), .PG_W(P_PG_W), .IDX_W(P_IDX_W), .LVL_W(P_LVL_W))
    u_nl (.lvl(nl), .below(nl_mask));
  iopt_span #(.W(P_VA_W), .PG_W(P_PG_W), .IDX_W(P_IDX_W), .LVL_W(P_LVL_W))
    u_st (.lvl(req_level), .below(st_mask));

  assign skip_bad      = |(va_q & off_mask[P_VA_W-1:0] & ~nl_mask);
  assign leaf_pa       = (mem_rsp_data[P_PA_W-1:0] & ~off_mask) | (P_PA_W'(va_q) & off_mask);
  assign start_lvl_bad = (req_level == '0) || (req_level > P_LVL_W'(P_MAX_LVL));
  assign start_skip    = |(req_iova & ~st_mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      va_q   <= '0;
      base_q <= '0;
      lvl_q  <= '0;
      pa_q   <= '0;
      ft_q   <= FT_NONE;
    end else begin
      case (st_q)
        ST_IDLE: if (req_valid) begin
          va_q   <= req_iova;
          base_q <= req_root;
          lvl_q  <= req_level;
          pa_q   <= '0;
          ft_q   <= FT_NONE;
          if (start_lvl_bad) begin
            ft_q <= FT_BADENT;
            st_q <= ST_RESP;
          end else if (start_skip) begin
            ft_q <= FT_SKIPNZ;
            st_q <= ST_RESP;
          end else begin
            st_q <= ST_FETCH;
          end
        end
        ST_FETCH: if (mem_req_ready) st_q <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) begin
          if (!present) begin
            ft_q <= FT_NOTPRES;
            st_q <= ST_RESP;
          end else if (nl == NL_RSVD || nl >= lvl_q) begin
            ft_q <= FT_BADENT;
            st_q <= ST_RESP;
          end else if (nl == '0) begin
            pa_q <= leaf_pa;
            st_q <= ST_RESP;
          end else if (skip_bad) begin
            ft_q <= FT_SKIPNZ;
            st_q <= ST_RESP;
          end else begin
            base_q <= mem_rsp_data[P_PA_W-1:P_PG_W];
            lvl_q  <= nl;
            st_q   <= ST_FETCH;
          end
        end
        ST_RESP: if (rsp_ready) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (st_q == ST_IDLE);
  assign mem_req_valid = (st_q == ST_FETCH);
  assign mem_rsp_ready = (st_q == ST_WAIT);
  assign rsp_valid     = (st_q == ST_RESP);
  assign rsp_pa        = pa_q;
  assign rsp_ftype     = ft_q;
  assign rsp_fault     = (ft_q != FT_NONE);

  // R2
  resp_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ready |=> req_ready && !rsp_valid);
  // R3
  mem_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
  // R3
  addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_addr[2:0] == 3'b000);
  // R4
  not_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid && mem_rsp_ready && !mem_rsp_data[0] |=> rsp_valid && rsp_ftype == 2'd1);
  // R5
  bad_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_level == '0 |=> rsp_valid && rsp_ftype == 2'd2);
  // R8
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_pa) && $stable(rsp_ftype));
  // R8
  fault_pa_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_pa == '0);
endmodule

// File: tb/sim_iopt_walker.sv
module sim_iopt_walker;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [47:0] req_iova = '0;
  logic [39:0] req_root = '0;
  logic [2:0]  req_level = '0;
  logic        mem_req_valid, mem_req_ready;
  logic [51:0] mem_req_addr;
  logic        mem_rsp_valid, mem_rsp_ready;
  logic [63:0] mem_rsp_data;
  logic        rsp_valid, rsp_ready = 1'b0, rsp_fault;
  logic [51:0] rsp_pa;
  logic [1:0]  rsp_ftype;

  iopt_walker u0 (.*);

  int n_vec = 0, n_bad = 0;
  logic [63:0] mem [logic [51:0]];
  logic [51:0] exp_q [$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic set_ent(input logic [39:0] pg, input int idx, input logic [39:0] npg,
                         input logic [2:0] nl, input bit pres);
    mem[{pg, 12'h000} + 52'(idx) * 8] = {12'h000, npg, nl, 8'h00, pres};
  endtask

  function automatic logic [47:0] mkva(input int i4, i3, i2, i1, input logic [11:0] off);
    return {9'(i4), 9'(i3), 9'(i2), 9'(i1), off};
  endfunction

  // Behavioural reference walk; fills exp_q with the reads it expects.
  function automatic void ref_walk(input logic [47:0] va, input logic [39:0] root,
                                   input int lvl, output logic [51:0] pa, output logic [1:0] ft);
    int cur, sh, nl;
    logic [39:0] base;
    logic [63:0] e;
    logic [51:0] a;
    bit done;
    exp_q.delete();
    pa = '0;
    ft = 2'd0;
    if (lvl < 1 || lvl > 6) begin ft = 2'd2; return; end
    for (int b = 12 + 9 * lvl; b < 48; b++) if (va[b]) ft = 2'd3;
    if (ft != 0) return;
    base = root; cur = lvl; done = 0;
    while (!done) begin
      sh = 12 + 9 * (cur - 1);
      a = {base, 12'h000} + ((sh >= 48) ? 52'd0 : 52'((va >> sh) & 48'h1ff)) * 8;
      exp_q.push_back(a);
      e = mem.exists(a) ? mem[a] : 64'h0;
      nl = int'(e[11:9]);
      if (!e[0]) begin ft = 2'd1; done = 1; end
      else if (nl == 7 || nl >= cur) begin ft = 2'd2; done = 1; end
      else if (nl == 0) begin
        for (int b = 0; b < 52; b++) pa[b] = (b < sh) ? ((b < 48) ? va[b] : 1'b0) : e[b];
        done = 1;
      end else begin
        for (int b = 12 + 9 * nl; b < sh && b < 48; b++) if (va[b]) ft = 2'd3;
        if (ft != 0) done = 1;
        else begin base = e[51:12]; cur = nl; end
      end
    end
  endfunction

  // Memory model: random ready and latency, address compared every cycle (R3, R9).
  initial begin
    bit pend = 0, ron = 0, stalled = 0;
    int lat = 0;
    logic [51:0] paddr = '0, last = '0, e;
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      mem_req_ready = 1'b0;
      if (ron) begin mem_rsp_valid = 1'b0; ron = 0; end
      if (pend) begin
        if (lat == 0) begin
          chk(mem_rsp_ready == 1'b1, "R9", "mem_rsp_ready", 64'(mem_rsp_ready), 64'd1);
          mem_rsp_valid = 1'b1;
          mem_rsp_data = mem.exists(paddr) ? mem[paddr] : 64'h0;
          pend = 0; ron = 1;
        end else lat--;
      end else if (mem_req_valid) begin
        if (stalled) chk(mem_req_addr == last, "R3", "addr held", 64'(mem_req_addr), 64'(last));
        if ($urandom_range(0, 2) != 0) begin
          mem_req_ready = 1'b1;
          stalled = 0;
          if (exp_q.size() == 0) chk(0, "R3", "unexpected read", 64'(mem_req_addr), 64'h0);
          else begin
            e = exp_q.pop_front();
            chk(mem_req_addr == e, "R3", "entry addr", 64'(mem_req_addr), 64'(e));
          end
          paddr = mem_req_addr; pend = 1; lat = $urandom_range(0, 2);
        end else begin
          stalled = 1; last = mem_req_addr;
        end
      end
    end
  end

  task automatic run(input logic [47:0] va, input logic [39:0] root, input int lvl,
                     input string tag);
    logic [51:0] epa, hpa;
    logic [1:0] eft, hft;
    int guard = 0;
    ref_walk(va, root, lvl, epa, eft);
    @(negedge clk);
    chk(req_ready == 1'b1, "R2", "idle ready", 64'(req_ready), 64'd1);
    req_valid = 1'b1; req_iova = va; req_root = root; req_level = 3'(lvl);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid && guard < 200) begin
      chk(req_ready == 1'b0, "R2", "busy ready", 64'(req_ready), 64'd0);
      @(negedge clk);
      guard++;
    end
    hpa = rsp_pa; hft = rsp_ftype;
    repeat ($urandom_range(0, 2)) begin
      @(negedge clk);
      chk(rsp_valid && rsp_pa == hpa && rsp_ftype == hft, "R8", "held result",
          64'(rsp_pa), 64'(hpa));
    end
    chk(rsp_pa == epa, tag, "pa", 64'(rsp_pa), 64'(epa));
    chk(rsp_ftype == eft, tag, "ftype", 64'(rsp_ftype), 64'(eft));
    chk(rsp_fault == (eft != 0), "R8", "fault flag", 64'(rsp_fault), 64'(eft != 0));
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(!rsp_valid && exp_q.size() == 0, "R3", "reads done", 64'(exp_q.size()), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    set_ent(40'h100, 1, 40'h200, 3'd3, 1);
    set_ent(40'h100, 2, 40'h600, 3'd2, 1);
    set_ent(40'h200, 2, 40'h300, 3'd2, 1);
    set_ent(40'h200, 3, 40'h40000, 3'd0, 1);
    set_ent(40'h200, 5, 40'h900, 3'd3, 1);
    set_ent(40'h200, 6, 40'h400, 3'd1, 1);
    set_ent(40'h300, 0, 40'h400, 3'd1, 1);
    set_ent(40'h300, 1, 40'h12345, 3'd0, 1);
    set_ent(40'h300, 2, 40'h500, 3'd7, 1);
    set_ent(40'h300, 3, 40'h500, 3'd2, 1);
    for (int i = 0; i < 4; i++) set_ent(40'h600, i, 40'h800 + 40'(i) * 40'h200, 3'd0, 1);
    for (int i = 0; i < 8; i++) set_ent(40'h400, i, 40'h5000 + 40'(i), 3'd0, 1);
    set_ent(40'h400, 8, 40'h7777, 3'd0, 0);
    set_ent(40'h700, 0, 40'h100, 3'd4, 1);
    set_ent(40'h710, 0, 40'h100, 3'd4, 1);

    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1", "req_ready", 64'(req_ready), 64'd1);
    chk(mem_req_valid == 1'b0, "R1", "mem_req_valid", 64'(mem_req_valid), 64'd0);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid", 64'(rsp_valid), 64'd0);
    rst_n = 1'b1;

    run(mkva(1, 2, 0, 5, 12'habc), 40'h100, 4, "R7");   // 4 KB page
    run(mkva(1, 2, 1, 9'h155, 12'h123), 40'h100, 4, "R7"); // 2 MB page
    run(mkva(1, 3, 9'h1ab, 9'h0cd, 12'hfed), 40'h100, 4, "R7"); // 1 GB page
    run(mkva(2, 0, 1, 7, 12'h010), 40'h100, 4, "R6");   // skip level 3
    run(mkva(2, 5, 1, 7, 12'h010), 40'h100, 4, "R6");   // skipped bits nonzero
    run(mkva(1, 6, 0, 3, 12'h000), 40'h100, 4, "R6");   // skip level 2
    run(mkva(1, 6, 4, 3, 12'h000), 40'h100, 4, "R6");
    run(mkva(1, 4, 0, 0, 12'h000), 40'h100, 4, "R4");
    run(mkva(3, 0, 0, 0, 12'h000), 40'h100, 4, "R4");
    run(mkva(1, 2, 0, 8, 12'h000), 40'h100, 4, "R4");
    run(mkva(1, 5, 0, 0, 12'h000), 40'h100, 4, "R5");
    run(mkva(1, 2, 2, 0, 12'h000), 40'h100, 4, "R5");   // code 7
    run(mkva(1, 2, 3, 0, 12'h000), 40'h100, 4, "R5");   // code equal to level
    run(mkva(1, 2, 0, 5, 12'h000), 40'h100, 0, "R5");
    run(mkva(1, 2, 0, 5, 12'h000), 40'h100, 7, "R5");
    run(mkva(1, 2, 0, 5, 12'h000), 40'h200, 3, "R6");   // top bits nonzero
    run(mkva(0, 2, 0, 5, 12'h321), 40'h200, 3, "R3");
    run(mkva(1, 2, 0, 6, 12'h444), 40'h700, 5, "R3");
    run(mkva(2, 0, 3, 1, 12'h555), 40'h710, 6, "R3");
    for (int k = 0; k < 40; k++) begin
      int lv;
      lv = ($urandom_range(0, 4) == 0) ? 3 : 4;
      run(mkva($urandom_range(0, 3), $urandom_range(0, 6), $urandom_range(0, 3),
               $urandom_range(0, 9), 12'($urandom)),
          (lv == 3) ? 40'h200 : 40'h100, lv, "R7");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule